// File: doc/BRIEF.md
# Processor Bus Cycle Decoder

This block sits beside a processor's bus interface. It watches the cycle-definition pins and turns each bus cycle into one command strobe that stays up for the whole cycle. The pins are memory-or-I/O, data-or-code and write-or-read. On the clock where the active-low address strobe is sampled low, it captures these three pins together with the processor's active-low cacheability indication and the system's active-low cache-enable reply. It then decodes them into one of eight one-hot command strobes.

From the same captured values it decides whether the cycle moves one beat or a four-beat burst. A burst is a line fill on a cacheable read or a write-back on a cacheable memory write. It counts the active-low ready pulses and raises a one-clock cycle-done signal on the ready that completes the cycle. A cacheability indication seen during an I/O cycle is a protocol violation, and it raises an error flag for that cycle.

Downstream logic such as chip-select and output-enable generation uses the strobes directly. That logic lies outside this block.

Top module: `bus_cycle_decoder`

## Requirements
- R1: A cycle is captured on a rising clock edge where `ads_n` is low and no cycle is in progress. While a cycle is in progress, `ads_n` and the definition and cache pins are ignored, except on the clock of the cycle's final ready (R9). While idle, `cmd`, `burst` and `cache_io_err` are all zero.
- R2: From the clock after capture, exactly one bit of `cmd` is high. Its index is {`mem_io`,`data_code`,`write_rd`} read as a 3-bit number: 0 interrupt acknowledge, 1 special, 2 I/O read, 3 I/O write, 4 code fetch, 5 invalid, 6 memory read, 7 memory write.
- R3: A code fetch (index 4) or memory read (index 6) is a four-beat burst (`burst`=1) when both `cache_n` and `ken_n` were low at capture. Otherwise it is a single beat.
- R4: A memory write (index 7) is a four-beat burst when `cache_n` was low at capture. Every other write, and the I/O write, is a single beat.
- R5: `cache_io_err` is high for the whole cycle when `mem_io` was low and `cache_n` was low at capture. Otherwise it is low.
- R6: `cmd`, `burst` and `cache_io_err` hold their values from capture until the rising edge that samples the final ready, and are zero on the following clock unless a new cycle starts on that edge.
- R7: `cycle_done` is high, combinationally, only while a cycle is in progress and `rdy_n` is low on its final beat: the 1st ready for a single cycle, the 4th for a burst. Ready pulses while idle have no effect.
- R8: The invalid code (index 5) and both interrupt-acknowledge cycles (index 0) are single-beat cycles. Each interrupt-acknowledge cycle is decoded on its own.
- R9: When `ads_n` is low on the same edge as the final ready, the new cycle is captured on that edge with no idle clock between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_n | input | 1 | Active-low address strobe |
| mem_io | input | 1 | 1 memory, 0 I/O |
| data_code | input | 1 | 1 data, 0 code |
| write_rd | input | 1 | 1 write, 0 read |
| cache_n | input | 1 | Active-low processor cacheability indication |
| ken_n | input | 1 | Active-low cache-enable reply |
| rdy_n | input | 1 | Active-low ready, one per transfer |
| cmd | output | 8 | One-hot command strobes, index per R2 |
| burst | output | 1 | Current cycle is a four-beat burst |
| cycle_done | output | 1 | Final ready of the current cycle |
| cache_io_err | output | 1 | Cacheability seen in an I/O cycle |

## Verification
The assertions check, on every clock, several properties:
- the strobes are one-hot;
- a burst appears only with a code fetch, memory read or memory write, and never with the invalid code;
- the error flag appears only with an I/O-space command;
- the strobes stay unchanged until a ready arrives and clear after the final one;
- `cycle_done` lines up with an independently kept count of readies.

Some behaviour only the bench's scenarios can show:
- the exact mapping from each pin combination to a strobe and a transfer count;
- that pins and a strobe arriving mid-cycle are ignored;
- that ready pulses while idle do nothing;
- that a strobe coinciding with the final ready starts the next cycle at once.

The bench sweeps every definition code against every cache and cache-enable pairing with varied wait states.

// File: rtl/bcd_pkg.sv
// Package: shared cycle-kind encoding and sizes for the bus cycle decoder.
// Assumes the kind index is {mem_io, data_code, write_rd}.
package bcd_pkg;
    localparam int N_KINDS   = 8;
    localparam int BURST_LEN = 4;

    typedef enum logic [2:0] {
        K_INTA    = 3'd0,
        K_SPECIAL = 3'd1,
        K_IORD    = 3'd2,
        K_IOWR    = 3'd3,
        K_CODE    = 3'd4,
        K_INVALID = 3'd5,
        K_MEMRD   = 3'd6,
        K_MEMWR   = 3'd7
    } kind_e;
endpackage

// File: rtl/bcd_classify.sv
// Module: combinational classifier of raw processor pins.
// Produces the one-hot kind, the burst decision and the I/O cache error.
// Assumes inputs are only meaningful on the capture clock.
module bcd_classify
    import bcd_pkg::*;
#(
    parameter int KINDS = N_KINDS
) (
    input  logic             mem_io,
    input  logic             data_code,
    input  logic             write_rd,
    input  logic             cache_n,
    input  logic             ken_n,
    output logic [KINDS-1:0] kind_oh,
    output logic             is_burst,
    output logic             io_cache_err
);
    localparam int IDX_W = $clog2(KINDS);

    logic [IDX_W-1:0] idx;
    logic             rd_fill;
    logic             wr_back;

    assign idx = IDX_W'({mem_io, data_code, write_rd});

    // One comparator per kind builds the one-hot vector.
    for (genvar g = 0; g < KINDS; g++) begin : g_oh
        assign kind_oh[g] = (idx == IDX_W'(g));
    end

    // Burst decision from the cacheability handshake.
    always_comb begin
        rd_fill = 1'b0;
        wr_back = 1'b0;
        if (mem_io && !write_rd && !cache_n && !ken_n) rd_fill = 1'b1;
        if (idx == IDX_W'(K_MEMWR) && !cache_n)        wr_back = 1'b1;
        is_burst = rd_fill | wr_back;
    end

    assign io_cache_err = !mem_io && !cache_n;
endmodule

// File: rtl/bcd_capture.sv
// Module: holding register for the decoded cycle.
// Loads on a start, clears on a finish without a start, otherwise holds.
module bcd_capture #(
    parameter int KINDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [KINDS-1:0] kind_d,
    input  logic             burst_d,
    input  logic             err_d,
    output logic [KINDS-1:0] kind_q,
    output logic             burst_q,
    output logic             err_q
);
    // Hold the decoded cycle for its whole length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            burst_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (load) begin
            kind_q  <= kind_d;
            burst_q <= burst_d;
            err_q   <= err_d;
        end else if (clear) begin
            kind_q  <= '0;
            burst_q <= 1'b0;
            err_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/bcd_beat_counter.sv
// Module: counts ready pulses of the cycle in progress and flags the last.
// Assumes start coincides with the capture edge.
module bcd_beat_counter #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic burst,
    input  logic rdy_n,
    output logic done
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CNT_W-1:0] cnt;
    logic             on_last;

    assign on_last = !burst || (cnt == CNT_W'(BEATS - 1));
    assign done    = active && !rdy_n && on_last;

    // Advance on each non-final ready, restart with every new cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (start)                   cnt <= '0;
        else if (active && !rdy_n && !done) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/bus_cycle_decoder.sv
// Module: top of the processor bus cycle decoder.
// Captures cycle-definition and cache pins on the address strobe, holds
// one-hot command strobes until the final ready, and reports burst,
// cycle completion and cacheable-I/O errors.
module bus_cycle_decoder
    import bcd_pkg::*;
#(
    parameter int KINDS = N_KINDS,
    parameter int BEATS = BURST_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads_n,
    input  logic             mem_io,
    input  logic             data_code,
    input  logic             write_rd,
    input  logic             cache_n,
    input  logic             ken_n,
    input  logic             rdy_n,
    output logic [KINDS-1:0] cmd,
    output logic             burst,
    output logic             cycle_done,
    output logic             cache_io_err
);
    logic [KINDS-1:0] kind_raw;
    logic             burst_raw;
    logic             err_raw;
    logic             active;
    logic             start;

    assign active = |cmd;
    assign start  = !ads_n && (!active || cycle_done);

    bcd_classify #(.KINDS(KINDS)) u_classify (
        .mem_io      (mem_io),
        .data_code   (data_code),
        .write_rd    (write_rd),
        .cache_n     (cache_n),
        .ken_n       (ken_n),
        .kind_oh     (kind_raw),
        .is_burst    (burst_raw),
        .io_cache_err(err_raw)
    );

    bcd_capture #(.KINDS(KINDS)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .clear  (cycle_done),
        .kind_d (kind_raw),
        .burst_d(burst_raw),
        .err_d  (err_raw),
        .kind_q (cmd),
        .burst_q(burst),
        .err_q  (cache_io_err)
    );

    bcd_beat_counter #(.BEATS(BEATS)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .active(active),
        .burst (burst),
        .rdy_n (rdy_n),
        .done  (cycle_done)
    );
endmodule

// File: rtl/bcd_checker.sv
// Module: assertion checker for bus_cycle_decoder, bound to the top.
// Keeps its own count of readies per cycle.
module bcd_checker #(
    parameter int KINDS = 8,
    parameter int BEATS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ads_n,
    input logic             rdy_n,
    input logic [KINDS-1:0] cmd,
    input logic             burst,
    input logic             cycle_done,
    input logic             cache_io_err
);
    logic [7:0] seen;

    // Independent ready count for the cycle in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                   seen <= '0;
        else if (cycle_done)          seen <= '0;
        else if (cmd != 0 && !rdy_n)  seen <= seen + 8'd1;
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd)); // R2
    AST_BURST_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> (cmd[4] || cmd[6] || cmd[7])); // R3
    AST_INVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd[5] |-> !burst); // R8
    AST_ERR_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cache_io_err |-> (cmd[0] || cmd[1] || cmd[2] || cmd[3])); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 0) |-> (!burst && !cache_io_err && !cycle_done)); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 0 && rdy_n) |=> $stable(cmd)); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && ads_n) |=> (cmd == 0)); // R6
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (burst ? (seen == 8'(BEATS - 1)) : (seen == 8'd0))); // R7
endmodule

bind bus_cycle_decoder bcd_checker #(.KINDS(KINDS), .BEATS(BEATS)) u_bcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ads_n       (ads_n),
    .rdy_n       (rdy_n),
    .cmd         (cmd),
    .burst       (burst),
    .cycle_done  (cycle_done),
    .cache_io_err(cache_io_err)
);

// File: tb/tb_bus_cycle_decoder.sv
module tb_bus_cycle_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_n = 1'b1;
    logic       mem_io = 1'b0, data_code = 1'b0, write_rd = 1'b0;
    logic       cache_n = 1'b1, ken_n = 1'b1, rdy_n = 1'b1;
    logic [7:0] cmd;
    logic       burst, cycle_done, cache_io_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_decoder dut (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mem_io(mem_io),
        .data_code(data_code), .write_rd(write_rd), .cache_n(cache_n),
        .ken_n(ken_n), .rdy_n(rdy_n), .cmd(cmd), .burst(burst),
        .cycle_done(cycle_done), .cache_io_err(cache_io_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_pins(input int code, input logic c_n, input logic k_n);
        mem_io = code[2]; data_code = code[1]; write_rd = code[0];
        cache_n = c_n; ken_n = k_n;
    endtask

    function automatic logic exp_burst(input int code, input logic c_n, input logic k_n);
        return ((code == 4 || code == 6) && !c_n && !k_n) || (code == 7 && !c_n);
    endfunction

    // One full cycle; all drives happen just after a falling edge.
    task automatic run_cycle(input int code, input logic c_n, input logic k_n, input int wt);
        logic [7:0] ecmd;
        logic eb, ee;
        int beats;
        ecmd = 8'(1) << code;
        eb = exp_burst(code, c_n, k_n);
        ee = (code < 4) && !c_n;
        beats = eb ? 4 : 1;
        @(negedge clk);
        set_pins(code, c_n, k_n);
        ads_n = 1'b0;
        @(negedge clk);
        ads_n = 1'b1;
        set_pins(7 - code, ~c_n, ~k_n);
        #1;
        chk("R2 cmd", cmd, ecmd);
        chk("R3/R4 burst", 8'(burst), 8'(eb));
        chk("R5 err", 8'(cache_io_err), 8'(ee));
        if (code == 5 || code == 0) chk("R8 single", 8'(burst), 8'd0);
        for (int b = 0; b < beats; b++) begin
            for (int w = 0; w < wt; w++) begin
                ads_n = (w == 0) ? 1'b0 : 1'b1;   // stray strobe mid-cycle
                #1;
                chk("R7 no early done", 8'(cycle_done), 8'd0);
                @(negedge clk);
                ads_n = 1'b1;
                #1;
                chk("R1 ignored mid-cycle", cmd, ecmd);
            end
            rdy_n = 1'b0;
            #1;
            chk("R7 done on last beat", 8'(cycle_done), 8'(b == beats - 1));
            @(negedge clk);
            rdy_n = 1'b1;
            #1;
            if (b < beats - 1) chk("R6 held", cmd, ecmd);
        end
        chk("R6 cleared", cmd, 8'd0);
        chk("R6 burst cleared", 8'(burst), 8'd0);
        chk("R6 err cleared", 8'(cache_io_err), 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset cmd", cmd, 8'd0);
        chk("R1 reset flags", {5'd0, burst, cycle_done, cache_io_err}, 8'd0);

        // Ready while idle must not do anything.
        @(negedge clk);
        rdy_n = 1'b0;
        #1;
        chk("R7 idle ready", 8'(cycle_done), 8'd0);
        @(negedge clk);
        rdy_n = 1'b1;
        #1;
        chk("R7 idle ready cmd", cmd, 8'd0);

        // Sweep every code with every cache/enable pairing.
        for (int code = 0; code < 8; code++)
            for (int cc = 0; cc < 4; cc++)
                run_cycle(code, cc[0], cc[1], (code + cc) % 3);

        // Two interrupt-acknowledge cycles in a row, each single.
        run_cycle(0, 1'b1, 1'b1, 0);
        run_cycle(0, 1'b1, 1'b1, 1);

        // R9: new strobe on the final ready of a single memory read.
        @(negedge clk);
        set_pins(6, 1'b1, 1'b1);
        ads_n = 1'b0;
        @(negedge clk);
        set_pins(3, 1'b1, 1'b1);
        ads_n = 1'b0;
        rdy_n = 1'b0;
        #1;
        chk("R9 done with new strobe", 8'(cycle_done), 8'd1);
        @(negedge clk);
        ads_n = 1'b1;
        rdy_n = 1'b1;
        #1;
        chk("R9 back-to-back cmd", cmd, 8'h08);
        rdy_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1;
        #1;
        chk("R9 second cycle ends", cmd, 8'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule